// File: doc/BRIEF.md
# Automatic level control gain engine

This block closes a digital automatic level control loop around the programmable-gain amplifier of a stereo recording path. Each channel supplies a signed peak level in 1.5 dB units relative to full scale. The block compares that level with a programmable target and produces a 5-bit amplifier gain code for each channel. When the level is above the target, the gain falls one step per attack interval. When the level is below the target, the block first waits out a hold interval and then raises the gain one step per decay interval. The gain never rises above a programmable ceiling.

A two-bit mode selects which channels the loop drives. The left channel only, the right channel only, or both with one shared gain. In the off mode both channels take their gain from manual inputs. All intervals come from one prescaled tick, and each code doubles the interval. New gain values can be held back until the controlled signal changes sign, or until a programmable clock timeout expires.

Configuration lives in two 16-bit registers, written through a simple write strobe and read back combinationally.

Top module: `alc_gain_engine`

## Requirements
- R1: After reset the control register (address 0) reads 16'h3E00 and the loop register (address 1) reads 16'hB032. A write with cfgWe high stores cfgWdata into the register picked by cfgAddr. Control register fields: [15:14] mode, [13:11] ceiling code, [10:9] zero-cross timeout code n, [8] zero-cross enable. Loop register fields: [15:12] target code, [11:8] hold code, [7:4] decay code, [3:0] attack code.
- R2: Mode 2'b00 drives gainL from manGainL and gainR from manGainR, and the loop makes no steps. Mode 2'b01 puts the loop gain on gainR and manGainL on gainL. Mode 2'b10 puts the loop gain on gainL and manGainR on gainR. Mode 2'b11 puts the shared loop gain on both outputs.
- R3: Gain code g means (1.5·g − 12) dB. The ceiling is 4 × ceiling code, so code 0 is −12 dB and code 7 is +30 dB. The loop gain never exceeds the ceiling, and a lowered ceiling clamps the loop gain on the next clock.
- R4: While the level is above the target, the loop gain drops by exactly one code per attack interval and stops at code 0.
- R5: The attack interval is ATK_BASE·2^min(code,10) ticks, and one tick is TICK_DIV clocks.
- R6: While the level is below the target and the hold interval has expired, the loop gain rises by one code per decay interval of DEC_BASE·2^min(code,10) ticks, up to the ceiling.
- R7: The hold interval is 0 for hold code 0, otherwise HOLD_BASE·2^(code−1) ticks. The hold interval restarts whenever the level is at or above the target.
- R8: The level inputs are signed, in 1.5 dB units with 0 meaning 0 dBFS. The target threshold is (target code − 19). A level equal to the threshold moves the gain neither way.
- R9: In mode 2'b11 the larger of levelL and levelR drives the shared gain decision.
- R10: With zero-cross enable at 0, the output gain follows the loop gain one clock later. With enable at 1, a changed loop gain reaches the outputs only when a sample sign of a controlled channel flips (sampValid high) or after 2^(ZC_BASE_SH+n) clocks, whichever comes first.
- R11: The loop gain and the applied gain reset to code 8 (0 dB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 1 | Register select: 0 control, 1 loop |
| cfgWdata | input | 16 | Register write data |
| cfgRdata | output | 16 | Read data of the selected register |
| levelValid | input | 1 | Level inputs carry a new measurement |
| levelL | input | LVL_W | Left peak level, signed, 1.5 dB units |
| levelR | input | LVL_W | Right peak level, signed, 1.5 dB units |
| sampValid | input | 1 | Sample sign inputs are valid |
| sampSignL | input | 1 | Sign bit of the current left sample |
| sampSignR | input | 1 | Sign bit of the current right sample |
| manGainL | input | GAIN_W | Manual left gain code |
| manGainR | input | GAIN_W | Manual right gain code |
| gainL | output | GAIN_W | Left amplifier gain code |
| gainR | output | GAIN_W | Right amplifier gain code |

## Verification
The bound checker watches these properties on every clock: the loop gain stays under the ceiling, each loop-gain change is a single step or a clamp, the outputs in the off and stereo modes, the one-clock follow with zero-cross deferral off, and that no gain is committed while deferral waits. Only the bench scenarios can show the timing. It measures the spacing between steps for several attack and decay codes, including the saturated codes. It measures the hold latency and its restart after an at-target interval, the threshold mapping, the choice of the larger channel, and whether a deferred gain lands on a sign flip or on the timeout.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RIGHT  = 2'b01,
    MODE_LEFT   = 2'b10,
    MODE_STEREO = 2'b11
  } alc_mode_e;

  typedef struct packed {
    alc_mode_e  mode;
    logic [2:0] maxGain;
    logic [1:0] zcTimeout;
    logic       zcEn;
    logic [3:0] target;
    logic [3:0] holdCode;
    logic [3:0] decayCode;
    logic [3:0] attackCode;
  } alc_cfg_t;

  // control -> datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic commit;
  } alc_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic over;
    logic under;
    logic pending;
    logic crossing;
  } alc_status_t;

  localparam logic [15:0] CTRL_REG_RST = 16'h3E00;
  localparam logic [15:0] LOOP_REG_RST = 16'hB032;
  localparam int          RATE_SAT     = 10;
  localparam int          TARGET_OFS   = 19;

endpackage

// File: rtl/alc_regs.sv
module alc_regs
  import alc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        cfgAddr,
  input  logic [15:0] cfgWdata,
  output logic [15:0] cfgRdata,
  output alc_cfg_t    cfg
);

  logic [15:0] ctrlReg;
  logic [15:0] loopReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_REG_RST;
      loopReg <= LOOP_REG_RST;
    end else if (cfgWe) begin
      if (cfgAddr) loopReg <= cfgWdata;
      else         ctrlReg <= cfgWdata;
    end
  end

  assign cfgRdata = cfgAddr ? loopReg : ctrlReg;

  always_comb begin
    cfg.mode       = alc_mode_e'(ctrlReg[15:14]);
    cfg.maxGain    = ctrlReg[13:11];
    cfg.zcTimeout  = ctrlReg[10:9];
    cfg.zcEn       = ctrlReg[8];
    cfg.target     = loopReg[15:12];
    cfg.holdCode   = loopReg[11:8];
    cfg.decayCode  = loopReg[7:4];
    cfg.attackCode = loopReg[3:0];
  end

endmodule

// File: rtl/alc_ctrl.sv
module alc_ctrl
  import alc_pkg::*;
#(
  parameter int TICK_DIV   = 1024,
  parameter int HOLD_BASE  = 4,
  parameter int DEC_BASE   = 36,
  parameter int ATK_BASE   = 9,
  parameter int ZC_BASE_SH = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  alc_mode_e   mode,
  input  logic        zcEn,
  input  logic [1:0]  zcTimeout,
  input  logic [3:0]  holdCode,
  input  logic [3:0]  decayCode,
  input  logic [3:0]  attackCode,
  input  alc_status_t status,
  output alc_strobe_t strobe
);

  localparam int MAX_HOLD = HOLD_BASE << 14;
  localparam int MAX_DEC  = DEC_BASE << RATE_SAT;
  localparam int MAX_ATK  = ATK_BASE << RATE_SAT;
  localparam int MAX_RATE = (MAX_DEC > MAX_ATK) ? MAX_DEC : MAX_ATK;
  localparam int MAX_LEN  = (MAX_HOLD > MAX_RATE) ? MAX_HOLD : MAX_RATE;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);
  localparam int TICK_W   = $clog2(TICK_DIV + 1);
  localparam int ZC_W     = ZC_BASE_SH + 4;

  typedef enum logic [1:0] {DIR_EQ, DIR_OVER, DIR_UNDER} dir_e;

  function automatic logic [CNT_W-1:0] rateLen(input int base, input logic [3:0] code);
    logic [3:0]       satCode;
    logic [CNT_W-1:0] baseVal;
    satCode = (code > 4'(RATE_SAT)) ? 4'(RATE_SAT) : code;
    baseVal = CNT_W'(base);
    return baseVal << satCode;
  endfunction

  logic [TICK_W-1:0] tickCnt;
  logic              tick;
  logic [CNT_W-1:0]  holdCnt, rateCnt;
  logic [CNT_W-1:0]  holdLen, atkLen, decLen;
  logic [CNT_W:0]    rateNext;
  logic              atkHit, decHit, holdDone;
  logic [ZC_W-1:0]   toCnt, toLen;
  logic              toHit;
  dir_e              dirNow, prevDir;
  logic              loopOn, counting;

  assign tick     = (tickCnt == TICK_W'(TICK_DIV - 1));
  assign loopOn   = (mode != MODE_OFF);
  assign dirNow   = status.over ? DIR_OVER : (status.under ? DIR_UNDER : DIR_EQ);
  assign counting = loopOn && (dirNow == prevDir) && (dirNow != DIR_EQ);

  assign holdLen  = (holdCode == 4'd0) ? '0
                  : (CNT_W'(HOLD_BASE) << (holdCode - 4'd1));
  assign atkLen   = rateLen(ATK_BASE, attackCode);
  assign decLen   = rateLen(DEC_BASE, decayCode);
  assign rateNext = {1'b0, rateCnt} + (CNT_W+1)'(1);
  assign atkHit   = rateNext >= {1'b0, atkLen};
  assign decHit   = rateNext >= {1'b0, decLen};
  assign holdDone = (holdCnt >= holdLen);

  assign toLen = ZC_W'(1) << (ZC_BASE_SH + int'(zcTimeout));
  assign toHit = (toCnt == toLen - ZC_W'(1));

  always_comb begin
    strobe.stepDown = counting && tick && (dirNow == DIR_OVER) && atkHit;
    strobe.stepUp   = counting && tick && (dirNow == DIR_UNDER) && holdDone && decHit;
    strobe.commit   = status.pending && (!zcEn || status.crossing || toHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      holdCnt <= '0;
      rateCnt <= '0;
      prevDir <= DIR_EQ;
      toCnt   <= '0;
    end else begin
      tickCnt <= tick ? '0 : tickCnt + TICK_W'(1);
      prevDir <= dirNow;

      // hold restarts at or above target
      if (!loopOn || dirNow != DIR_UNDER) begin
        holdCnt <= '0;
      end else if (tick && !holdDone) begin
        holdCnt <= holdCnt + CNT_W'(1);
      end

      if (!counting) begin
        rateCnt <= '0;
      end else if (tick) begin
        if (dirNow == DIR_OVER) begin
          rateCnt <= atkHit ? '0 : rateNext[CNT_W-1:0];
        end else if (holdDone) begin
          rateCnt <= decHit ? '0 : rateNext[CNT_W-1:0];
        end
      end

      if (!status.pending || strobe.commit) toCnt <= '0;
      else                                  toCnt <= toCnt + ZC_W'(1);
    end
  end

endmodule

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
#(
  parameter int GAIN_W   = 5,
  parameter int LVL_W    = 8,
  parameter int GAIN_RST = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  alc_mode_e               mode,
  input  logic [2:0]              maxGain,
  input  logic [3:0]              target,
  input  alc_strobe_t             strobe,
  input  logic                    levelValid,
  input  logic signed [LVL_W-1:0] levelL,
  input  logic signed [LVL_W-1:0] levelR,
  input  logic                    sampValid,
  input  logic                    sampSignL,
  input  logic                    sampSignR,
  input  logic [GAIN_W-1:0]       manGainL,
  input  logic [GAIN_W-1:0]       manGainR,
  output alc_status_t             status,
  output logic [GAIN_W-1:0]       loopGain,
  output logic [GAIN_W-1:0]       appliedGain,
  output logic [GAIN_W-1:0]       gainL,
  output logic [GAIN_W-1:0]       gainR
);

  logic signed [LVL_W-1:0] levelSel, levelPick, tgtLvl;
  logic [GAIN_W-1:0]       limit;
  logic                    prevSignL, prevSignR, seenSamp;
  logic                    crossL, crossR;
  logic                    driveL, driveR;

  always_comb begin
    case (mode)
      MODE_RIGHT: levelPick = levelR;
      MODE_LEFT:  levelPick = levelL;
      default:    levelPick = (levelL > levelR) ? levelL : levelR;
    endcase
  end

  assign tgtLvl = $signed(LVL_W'(target)) - $signed(LVL_W'(TARGET_OFS));
  assign limit  = GAIN_W'({maxGain, 2'b00});

  assign crossL = sampValid && seenSamp && (sampSignL != prevSignL);
  assign crossR = sampValid && seenSamp && (sampSignR != prevSignR);
  assign driveL = (mode == MODE_LEFT)  || (mode == MODE_STEREO);
  assign driveR = (mode == MODE_RIGHT) || (mode == MODE_STEREO);

  always_comb begin
    status.over     = levelSel > tgtLvl;
    status.under    = levelSel < tgtLvl;
    status.pending  = (appliedGain != loopGain);
    status.crossing = (driveL && crossL) || (driveR && crossR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelSel    <= tgtLvl;
      loopGain    <= GAIN_W'(GAIN_RST);
      appliedGain <= GAIN_W'(GAIN_RST);
      prevSignL   <= 1'b0;
      prevSignR   <= 1'b0;
      seenSamp    <= 1'b0;
    end else begin
      if (levelValid) levelSel <= levelPick;

      if (loopGain > limit) begin
        loopGain <= limit;
      end else if (strobe.stepDown && loopGain != '0) begin
        loopGain <= loopGain - GAIN_W'(1);
      end else if (strobe.stepUp && loopGain < limit) begin
        loopGain <= loopGain + GAIN_W'(1);
      end

      if (strobe.commit) appliedGain <= loopGain;

      if (sampValid) begin
        prevSignL <= sampSignL;
        prevSignR <= sampSignR;
        seenSamp  <= 1'b1;
      end
    end
  end

  assign gainL = driveL ? appliedGain : manGainL;
  assign gainR = driveR ? appliedGain : manGainR;

endmodule

// File: rtl/alc_gain_engine.sv
module alc_gain_engine
  import alc_pkg::*;
#(
  parameter int GAIN_W     = 5,
  parameter int LVL_W      = 8,
  parameter int TICK_DIV   = 1024,
  parameter int HOLD_BASE  = 4,
  parameter int DEC_BASE   = 36,
  parameter int ATK_BASE   = 9,
  parameter int ZC_BASE_SH = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic                    cfgAddr,
  input  logic [15:0]             cfgWdata,
  output logic [15:0]             cfgRdata,
  input  logic                    levelValid,
  input  logic signed [LVL_W-1:0] levelL,
  input  logic signed [LVL_W-1:0] levelR,
  input  logic                    sampValid,
  input  logic                    sampSignL,
  input  logic                    sampSignR,
  input  logic [GAIN_W-1:0]       manGainL,
  input  logic [GAIN_W-1:0]       manGainR,
  output logic [GAIN_W-1:0]       gainL,
  output logic [GAIN_W-1:0]       gainR
);

  alc_cfg_t          cfg;
  alc_strobe_t       strobe;
  alc_status_t       status;
  logic [GAIN_W-1:0] loopGain, appliedGain;

  alc_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .cfg      (cfg)
  );

  alc_ctrl #(
    .TICK_DIV   (TICK_DIV),
    .HOLD_BASE  (HOLD_BASE),
    .DEC_BASE   (DEC_BASE),
    .ATK_BASE   (ATK_BASE),
    .ZC_BASE_SH (ZC_BASE_SH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (cfg.mode),
    .zcEn       (cfg.zcEn),
    .zcTimeout  (cfg.zcTimeout),
    .holdCode   (cfg.holdCode),
    .decayCode  (cfg.decayCode),
    .attackCode (cfg.attackCode),
    .status     (status),
    .strobe     (strobe)
  );

  alc_datapath #(
    .GAIN_W (GAIN_W),
    .LVL_W  (LVL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .mode        (cfg.mode),
    .maxGain     (cfg.maxGain),
    .target      (cfg.target),
    .strobe      (strobe),
    .levelValid  (levelValid),
    .levelL      (levelL),
    .levelR      (levelR),
    .sampValid   (sampValid),
    .sampSignL   (sampSignL),
    .sampSignR   (sampSignR),
    .manGainL    (manGainL),
    .manGainR    (manGainR),
    .status      (status),
    .loopGain    (loopGain),
    .appliedGain (appliedGain),
    .gainL       (gainL),
    .gainR       (gainR)
  );

endmodule

// File: rtl/alc_gain_engine_chk.sv
module alc_gain_engine_chk
  import alc_pkg::*;
#(
  parameter int GAIN_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input alc_mode_e         mode,
  input logic [2:0]        maxGain,
  input logic              zcEn,
  input alc_strobe_t       strobe,
  input logic [GAIN_W-1:0] loopGain,
  input logic [GAIN_W-1:0] appliedGain,
  input logic [GAIN_W-1:0] manGainL,
  input logic [GAIN_W-1:0] manGainR,
  input logic [GAIN_W-1:0] gainL,
  input logic [GAIN_W-1:0] gainR
);

  logic [GAIN_W-1:0] ceiling;
  assign ceiling = GAIN_W'({maxGain, 2'b00});

  AST_GAIN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    $stable(maxGain) |-> loopGain <= ceiling); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loopGain) |-> (loopGain == $past(loopGain) + GAIN_W'(1)) ||
                           (loopGain + GAIN_W'(1) == $past(loopGain)) ||
                           (loopGain == ceiling)); // R4

  AST_OFF_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> (gainL == manGainL) && (gainR == manGainR)); // R2

  AST_OFF_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !strobe.stepUp && !strobe.stepDown); // R2

  AST_STEREO_SHARED: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STEREO) |-> gainL == gainR); // R9

  AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (!zcEn && !$past(zcEn) && mode == MODE_STEREO && $past(mode) == MODE_STEREO)
      |-> gainL == $past(loopGain)); // R10

  AST_ZC_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (zcEn && !strobe.commit) |=> $stable(appliedGain)); // R10

endmodule

bind alc_gain_engine alc_gain_engine_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .mode        (cfg.mode),
  .maxGain     (cfg.maxGain),
  .zcEn        (cfg.zcEn),
  .strobe      (strobe),
  .loopGain    (loopGain),
  .appliedGain (appliedGain),
  .manGainL    (manGainL),
  .manGainR    (manGainR),
  .gainL       (gainL),
  .gainR       (gainR)
);

// File: tb/alc_gain_engine_tb.sv
`timescale 1ns/1ps
module alc_gain_engine_tb;

  localparam int GW = 5;
  localparam int LW = 8;
  localparam int TD = 2;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 cfgWe = 1'b0;
  logic                 cfgAddr = 1'b0;
  logic [15:0]          cfgWdata = '0;
  logic [15:0]          cfgRdata;
  logic                 levelValid = 1'b0;
  logic signed [LW-1:0] levelL = '0;
  logic signed [LW-1:0] levelR = '0;
  logic                 sampValid = 1'b0;
  logic                 sampSignL = 1'b0;
  logic                 sampSignR = 1'b0;
  logic [GW-1:0]        manGainL = '0;
  logic [GW-1:0]        manGainR = '0;
  logic [GW-1:0]        gainL, gainR;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alc_gain_engine #(
    .GAIN_W(GW), .LVL_W(LW), .TICK_DIV(TD), .HOLD_BASE(1),
    .DEC_BASE(2), .ATK_BASE(1), .ZC_BASE_SH(3)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .levelValid(levelValid),
    .levelL(levelL), .levelR(levelR), .sampValid(sampValid),
    .sampSignL(sampSignL), .sampSignR(sampSignR), .manGainL(manGainL),
    .manGainR(manGainR), .gainL(gainL), .gainR(gainR)
  );

  typedef struct packed {
    logic [1:0]    mode;
    logic [GW-1:0] manL;
    logic [GW-1:0] manR;
    logic [GW-1:0] expL;
    logic [GW-1:0] expR;
  } vec_t;

  // loop gain sits at reset code 8 with the level held at the target
  localparam vec_t VECS [6] = '{
    '{2'd0, 5'd3,  5'd20, 5'd3,  5'd20},
    '{2'd1, 5'd3,  5'd20, 5'd3,  5'd8 },
    '{2'd2, 5'd3,  5'd20, 5'd8,  5'd20},
    '{2'd3, 5'd3,  5'd20, 5'd8,  5'd8 },
    '{2'd1, 5'd17, 5'd0,  5'd17, 5'd8 },
    '{2'd2, 5'd0,  5'd5,  5'd8,  5'd5 }
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [15:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = addr; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeCtrl(input logic [1:0] m, input logic [2:0] mg,
                           input logic [1:0] to, input logic zc);
    writeReg(1'b0, {m, mg, to, zc, 8'h00});
  endtask

  task automatic writeLoop(input logic [3:0] tg, input logic [3:0] hd,
                           input logic [3:0] dc, input logic [3:0] at);
    writeReg(1'b1, {tg, hd, dc, at});
  endtask

  task automatic setLevel(input int l, input int r);
    @(negedge clk);
    levelValid = 1'b1; levelL = LW'(l); levelR = LW'(r);
    @(negedge clk);
    levelValid = 1'b0;
  endtask

  task automatic waitChange(input int maxCyc, output int cyc);
    logic [GW-1:0] start;
    start = gainR;
    cyc = 0;
    while (cyc < maxCyc) begin
      @(negedge clk);
      cyc++;
      if (gainR != start) break;
    end
  endtask

  // cycles from the level drive to the first output change
  task automatic levelLatency(input int l, input int maxCyc, output int cyc);
    logic [GW-1:0] start;
    @(negedge clk);
    start = gainR;
    levelValid = 1'b1; levelL = LW'(l); levelR = LW'(l);
    cyc = 0;
    while (cyc < maxCyc) begin
      @(negedge clk);
      levelValid = 1'b0;
      cyc++;
      if (gainR != start) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int c, g0, g1;
    manGainL = 5'd3; manGainR = 5'd20;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset values; R2 off mode after reset
    cfgAddr = 1'b0; #1;
    check("R1 ctrl reset", int'(cfgRdata), 16'h3E00);
    cfgAddr = 1'b1; #1;
    check("R1 loop reset", int'(cfgRdata), 16'hB032);
    check("R2 off left manual", int'(gainL), 3);
    check("R2 off right manual", int'(gainR), 20);
    writeLoop(4'd11, 4'd0, 4'd3, 4'd5);
    cfgAddr = 1'b1; #1;
    check("R1 loop write", int'(cfgRdata), 16'hB035);

    // table: mode routing, R2 and R11 (reset gain 8); level = threshold -8
    setLevel(-8, -8);
    foreach (VECS[i]) begin
      writeCtrl(VECS[i].mode, 3'd7, 2'd3, 1'b0);
      manGainL = VECS[i].manL; manGainR = VECS[i].manR;
      idle(3);
      check("R2/R11 left", int'(gainL), int'(VECS[i].expL));
      check("R2/R11 right", int'(gainR), int'(VECS[i].expR));
    end

    // attack: stereo, larger right level above threshold (R9)
    writeCtrl(2'd3, 3'd7, 2'd3, 1'b0);
    writeLoop(4'd11, 4'd0, 4'd3, 4'd2);
    setLevel(-20, -2);
    waitChange(100, c);
    g0 = int'(gainR);
    check("R9 larger level drives attack", g0, 7);
    waitChange(100, c);
    check("R5 attack code 2 spacing", c, 4 * TD);
    check("R4 one step down", int'(gainR), g0 - 1);
    writeLoop(4'd11, 4'd0, 4'd3, 4'd12);
    waitChange(5000, c);
    waitChange(5000, c);
    check("R5 attack code 12 saturates", c, 1024 * TD);
    writeLoop(4'd11, 4'd0, 4'd3, 4'd0);
    waitChange(100, c);
    waitChange(100, c);
    check("R5 attack code 0 spacing", c, TD);
    idle(60);
    check("R4 floor at code 0", int'(gainR), 0);

    // decay with no hold
    writeLoop(4'd11, 4'd0, 4'd0, 4'd0);
    setLevel(-30, -30);
    waitChange(100, c);
    waitChange(100, c);
    check("R6 decay code 0 spacing", c, 2 * TD);
    writeLoop(4'd11, 4'd0, 4'd15, 4'd0);
    waitChange(10000, c);
    g0 = int'(gainR);
    waitChange(10000, c);
    check("R6 decay code 15 saturates", c, 2048 * TD);
    check("R6 one step up", int'(gainR), g0 + 1);
    writeLoop(4'd11, 4'd0, 4'd0, 4'd0);
    idle(300);
    check("R3 cap at ceiling 28", int'(gainR), 28);
    writeCtrl(2'd3, 3'd1, 2'd3, 1'b0);
    idle(2);
    check("R3/R10 clamp applied at once", int'(gainL), 4);

    // hold interval and restart
    setLevel(-8, -8);
    writeCtrl(2'd3, 3'd7, 2'd3, 1'b0);
    writeLoop(4'd11, 4'd3, 4'd0, 4'd0);
    idle(20);
    check("R8 equal level holds gain", int'(gainR), 4);
    levelLatency(-30, 100, c);
    checkRange("R7 hold code 3 latency", c, 2 * (4 + 2) + 1, 2 * (4 + 2) + 4);
    writeLoop(4'd11, 4'd0, 4'd0, 4'd0);
    setLevel(-8, -8);
    idle(6);
    levelLatency(-30, 100, c);
    checkRange("R7 hold code 0 latency", c, 2 * 2 + 1, 2 * 2 + 4);
    setLevel(-8, -8);
    writeLoop(4'd11, 4'd5, 4'd0, 4'd0);
    idle(6);
    g0 = int'(gainR);
    setLevel(-30, -30);
    idle(20);
    check("R7 no step inside hold", int'(gainR), g0);
    setLevel(-8, -8);
    idle(3);
    levelLatency(-30, 100, c);
    checkRange("R7 hold restarts at target", c, 2 * (16 + 2) + 1, 2 * (16 + 2) + 4);

    // target mapping: code 15 -> -4, code 0 -> -19
    writeLoop(4'd15, 4'd0, 4'd0, 4'd0);
    setLevel(-4, -4);
    idle(4);
    g0 = int'(gainR);
    idle(50);
    check("R8 code 15 threshold -4 is neutral", int'(gainR), g0);
    setLevel(-3, -3);
    idle(10);
    checkRange("R8 above code 15 threshold drops", int'(gainR), 0, g0 - 1);
    writeLoop(4'd0, 4'd0, 4'd0, 4'd0);
    setLevel(-19, -19);
    idle(4);
    g1 = int'(gainR);
    idle(50);
    check("R8 code 0 threshold -19 is neutral", int'(gainR), g1);
    setLevel(-20, -20);
    idle(20);
    checkRange("R8 below code 0 threshold rises", int'(gainR), g1 + 1, 28);

    // zero-cross deferral
    writeLoop(4'd11, 4'd0, 4'd0, 4'd0);
    setLevel(-30, -30);
    idle(300);
    setLevel(-8, -8);
    idle(4);
    check("R10 setup at ceiling", int'(gainR), 28);
    @(negedge clk);
    sampValid = 1'b1; sampSignL = 1'b0; sampSignR = 1'b0;
    @(negedge clk);
    sampValid = 1'b0;
    writeCtrl(2'd3, 3'd6, 2'd3, 1'b1);
    idle(40);
    check("R10 deferred while waiting", int'(gainL), 28);
    idle(40);
    check("R10 timeout n=3 commits", int'(gainL), 24);
    writeCtrl(2'd3, 3'd5, 2'd3, 1'b1);
    idle(8);
    check("R10 no crossing yet", int'(gainL), 24);
    @(negedge clk);
    sampValid = 1'b1; sampSignL = 1'b1;
    @(negedge clk);
    sampValid = 1'b0;
    idle(3);
    check("R10 sign flip commits", int'(gainL), 20);
    writeCtrl(2'd3, 3'd4, 2'd0, 1'b1);
    idle(4);
    check("R10 short timeout still waiting", int'(gainR), 20);
    idle(16);
    check("R10 timeout n=0 commits", int'(gainR), 16);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule